// File: doc/BRIEF.md
# Graphics DRAM Command Decoder with Mode Register

This block watches the command pins of a synchronous graphics DRAM from the memory side. On every rising clock edge with clock enable high, it samples chip select, the row strobe, the column strobe, the write enable, the special-function select, the bank bit and the address bus. From these it decodes a small set of commands. It keeps the programmed operating mode and tracks which banks are open.

Two commands do real work. A mode load writes burst length, burst ordering and CAS latency into the mode register. A masked block write with self-precharge names a bank, an 8-column block address and a 32-bit column mask; when accepted, the block reports it and then closes the bank by itself. An activate command opens a bank. After each accepted mode load or block write, a lockout window starts. A busy flag covers that window, and any real command issued inside it is rejected and recorded in a sticky flag. Sticky error flags also catch access before the first valid mode load, a mode load while a bank is open, illegal mode codes, and commands that do not fit the bank state.

Top module: `sgram_cmd_ctrl`

## Requirements
- R1: After reset, mode_valid, busy, all error flags, mrs_go and bw_go are 0, and every bit of bank_idle is 1.
- R2: With cs_n low, the pattern ras_n=0, cas_n=0, we_n=0, dsf=0 is a mode load. Its fields are: addr[2:0] burst code (0..3 give 1, 2, 4 or 8 beats on mode_burst), addr[3] interleaved order (mode_ilv), and addr[6:4] CAS latency 1..3 (mode_cl). An accepted load sets mode_valid and pulses mrs_go for one cycle. mode_valid never returns to 0 outside reset.
- R3: A mode load whose burst code is 4..7, whose latency code is 0 or 4..7, or whose addr[9:7] or bank bit is nonzero is rejected. It sets err_code and leaves the mode fields unchanged.
- R4: Before the first accepted mode load, an activate (ras_n=0, cas_n=1, we_n=1) or any command with ras_n=1, cas_n=0 is ignored and sets err_nomode.
- R5: An accepted activate clears bank_idle[ba].
- R6: A mode load while any bank_idle bit is 0 is rejected and sets err_seq.
- R7: The pattern ras_n=1, cas_n=0, we_n=1, dsf=1 with addr[9]=1 is a block write. When the bank is open, the next cycle shows bw_go=1, bw_bank=ba, bw_col=addr[7:3] and bw_mask=dq_mask.
- R8: After an accepted block write, busy stays high for exactly T_BPL+T_RP enabled clocks. bank_idle of that bank returns to 1 on the edge where busy falls.
- R9: After an accepted mode load, busy stays high for exactly MRS_GAP enabled clocks.
- R10: While busy, any command other than a no-op (cs_n=1, or ras_n=cas_n=we_n=1) is ignored and sets err_lock. No-ops set no flag. All error flags are sticky until reset.
- R11: While cke is 0, commands are ignored and neither the lockout counter nor the bank flags change.
- R12: A block write to an idle bank, or an activate to an open bank, is ignored and sets err_seq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable; low freezes the block |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| dsf | input | 1 | Special-function select |
| ba | input | 1 | Bank select |
| addr | input | 10 | Address bus / mode data |
| dq_mask | input | 32 | Column mask on the data pins |
| mode_valid | output | 1 | A legal mode has been loaded |
| mode_cl | output | 2 | CAS latency in clocks |
| mode_ilv | output | 1 | 1 = interleaved burst order |
| mode_burst | output | 4 | Burst length in beats |
| bank_idle | output | 2 | Per-bank idle flags |
| busy | output | 1 | Lockout window active |
| mrs_go | output | 1 | Mode load accepted last edge |
| bw_go | output | 1 | Block write accepted last edge |
| bw_bank | output | 1 | Bank of the accepted block write |
| bw_col | output | 5 | Block column address |
| bw_mask | output | 32 | Column mask of the block write |
| err_lock | output | 1 | Sticky: command inside lockout |
| err_nomode | output | 1 | Sticky: access before mode load |
| err_seq | output | 1 | Sticky: command against bank state |
| err_code | output | 1 | Sticky: illegal mode code |

## Verification
The bench builds the block with T_BPL=1, T_RP=2 and MRS_GAP=2. This gives a three-clock block-write window and a two-clock mode-load window. Because the mode-load gap is greater than one, a violation in the second lockout clock can be seen, and the window edges can be counted cycle by cycle in a short run. With these values the bench can also reach a clock-enable stall in the middle of a window, the bank reopening exactly as busy falls, and the sticky flags piling up across one sequence.

// File: rtl/sgram_cmd_pkg.sv
package sgram_cmd_pkg;
  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_MRS,
    CMD_ACT,
    CMD_BW,
    CMD_COL,
    CMD_MISC
  } cmd_e;

  localparam int MODE_BL_LSB = 0;
  localparam int MODE_ILV_BIT = 3;
  localparam int MODE_CL_LSB = 4;
  localparam int MODE_TOP_LSB = 7;
endpackage

// File: rtl/sgram_cmd_decode.sv
module sgram_cmd_decode
  import sgram_cmd_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic dsf,
  input  logic blk_sel,
  output cmd_e cmd
);
  always_comb begin
    cmd = CMD_NOP;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b111:  cmd = CMD_NOP;
        3'b000:  cmd = dsf ? CMD_MISC : CMD_MRS;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = (dsf && blk_sel) ? CMD_BW : CMD_COL;
        3'b100:  cmd = CMD_COL;
        default: cmd = CMD_MISC;
      endcase
    end
  end
endmodule

// File: rtl/sgram_mode_reg.sv
module sgram_mode_reg
  import sgram_cmd_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BA_W   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BA_W-1:0]   ba,
  output logic              code_ok,
  output logic              mode_valid,
  output logic [1:0]        mode_cl,
  output logic              mode_ilv,
  output logic [3:0]        mode_burst
);
  logic [2:0] bl_code;
  logic [2:0] cl_code;
  logic       top_zero;

  assign bl_code  = addr[MODE_BL_LSB +: 3];
  assign cl_code  = addr[MODE_CL_LSB +: 3];
  assign top_zero = (addr[ADDR_W-1:MODE_TOP_LSB] == '0) && (ba == '0);
  assign code_ok  = !bl_code[2] && (cl_code != 3'd0) && !cl_code[2] && top_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_valid <= 1'b0;
      mode_cl    <= 2'd0;
      mode_ilv   <= 1'b0;
      mode_burst <= 4'd0;
    end else if (wr) begin
      mode_valid <= 1'b1;
      mode_cl    <= cl_code[1:0];
      mode_ilv   <= addr[MODE_ILV_BIT];
      mode_burst <= 4'd1 << bl_code[1:0];
    end
  end
endmodule

// File: rtl/sgram_lockout.sv
module sgram_lockout #(
  parameter int CNT_W = 3,
  parameter int BA_W  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cke,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             load_bw,
  input  logic [BA_W-1:0]  load_bank,
  output logic             busy,
  output logic             expire,
  output logic [BA_W-1:0]  exp_bank
);
  logic [CNT_W-1:0] cnt;
  logic             kind_bw;

  assign expire = cke && kind_bw && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      busy     <= 1'b0;
      kind_bw  <= 1'b0;
      exp_bank <= '0;
    end else if (load) begin
      cnt      <= load_val;
      busy     <= (load_val != '0);
      kind_bw  <= load_bw;
      exp_bank <= load_bank;
    end else if (cke && cnt != '0) begin
      cnt  <= cnt - CNT_W'(1);
      busy <= (cnt != CNT_W'(1));
      if (cnt == CNT_W'(1)) kind_bw <= 1'b0;
    end
  end
endmodule

// File: rtl/sgram_bank_track.sv
module sgram_bank_track #(
  parameter int NUM_BANKS = 2,
  parameter int BA_W      = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 open_en,
  input  logic [BA_W-1:0]      open_bank,
  input  logic                 close_en,
  input  logic [BA_W-1:0]      close_bank,
  output logic [NUM_BANKS-1:0] idle
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        idle[b] <= 1'b1;
      end else if (open_en && open_bank == BA_W'(b)) begin
        idle[b] <= 1'b0;
      end else if (close_en && close_bank == BA_W'(b)) begin
        idle[b] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sgram_cmd_ctrl.sv
module sgram_cmd_ctrl
  import sgram_cmd_pkg::*;
#(
  parameter int T_BPL     = 2,
  parameter int T_RP      = 3,
  parameter int MRS_GAP   = 1,
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 10,
  parameter int DQ_W      = 32,
  parameter int COL_LO    = 3,
  parameter int COL_W     = 5,
  parameter int BLK_BIT   = 9,
  localparam int BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cke,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic                 dsf,
  input  logic [BA_W-1:0]      ba,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DQ_W-1:0]      dq_mask,
  output logic                 mode_valid,
  output logic [1:0]           mode_cl,
  output logic                 mode_ilv,
  output logic [3:0]           mode_burst,
  output logic [NUM_BANKS-1:0] bank_idle,
  output logic                 busy,
  output logic                 mrs_go,
  output logic                 bw_go,
  output logic [BA_W-1:0]      bw_bank,
  output logic [COL_W-1:0]     bw_col,
  output logic [DQ_W-1:0]      bw_mask,
  output logic                 err_lock,
  output logic                 err_nomode,
  output logic                 err_seq,
  output logic                 err_code
);
  localparam int LOCK_BW  = T_BPL + T_RP;
  localparam int LOCK_MAX = (LOCK_BW > MRS_GAP) ? LOCK_BW : MRS_GAP;
  localparam int CNT_W    = $clog2(LOCK_MAX + 1);

  cmd_e             cmd;
  logic             code_ok;
  logic             expire;
  logic [BA_W-1:0]  exp_bank;
  logic             live, lock_hit, free_cmd, is_access, all_idle, sel_idle;
  logic             nomode_hit;
  logic             mrs_try, mrs_ok, mrs_seq, mrs_bad;
  logic             act_try, act_ok, act_seq;
  logic             bw_try, bw_ok, bw_seq;
  logic [CNT_W-1:0] load_val;

  sgram_cmd_decode u_dec (
    .cs_n   (cs_n),
    .ras_n  (ras_n),
    .cas_n  (cas_n),
    .we_n   (we_n),
    .dsf    (dsf),
    .blk_sel(addr[BLK_BIT]),
    .cmd    (cmd)
  );

  assign live       = cke && (cmd != CMD_NOP);
  assign lock_hit   = live && busy;
  assign free_cmd   = live && !busy;
  assign is_access  = (cmd == CMD_ACT) || (cmd == CMD_BW) || (cmd == CMD_COL);
  assign all_idle   = &bank_idle;
  assign sel_idle   = bank_idle[ba];
  assign nomode_hit = free_cmd && !mode_valid && is_access;

  assign mrs_try = free_cmd && (cmd == CMD_MRS);
  assign mrs_ok  = mrs_try && all_idle && code_ok;
  assign mrs_seq = mrs_try && !all_idle;
  assign mrs_bad = mrs_try && all_idle && !code_ok;

  assign act_try = free_cmd && mode_valid && (cmd == CMD_ACT);
  assign act_ok  = act_try && sel_idle;
  assign act_seq = act_try && !sel_idle;

  assign bw_try  = free_cmd && mode_valid && (cmd == CMD_BW);
  assign bw_ok   = bw_try && !sel_idle;
  assign bw_seq  = bw_try && sel_idle;

  assign load_val = bw_ok ? CNT_W'(LOCK_BW) : CNT_W'(MRS_GAP);

  sgram_mode_reg #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_mode (
    .clk       (clk),
    .rst       (rst),
    .wr        (mrs_ok),
    .addr      (addr),
    .ba        (ba),
    .code_ok   (code_ok),
    .mode_valid(mode_valid),
    .mode_cl   (mode_cl),
    .mode_ilv  (mode_ilv),
    .mode_burst(mode_burst)
  );

  sgram_lockout #(.CNT_W(CNT_W), .BA_W(BA_W)) u_lock (
    .clk      (clk),
    .rst      (rst),
    .cke      (cke),
    .load     (mrs_ok || bw_ok),
    .load_val (load_val),
    .load_bw  (bw_ok),
    .load_bank(ba),
    .busy     (busy),
    .expire   (expire),
    .exp_bank (exp_bank)
  );

  sgram_bank_track #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) u_banks (
    .clk       (clk),
    .rst       (rst),
    .open_en   (act_ok),
    .open_bank (ba),
    .close_en  (expire),
    .close_bank(exp_bank),
    .idle      (bank_idle)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mrs_go     <= 1'b0;
      bw_go      <= 1'b0;
      bw_bank    <= '0;
      bw_col     <= '0;
      bw_mask    <= '0;
      err_lock   <= 1'b0;
      err_nomode <= 1'b0;
      err_seq    <= 1'b0;
      err_code   <= 1'b0;
    end else begin
      mrs_go <= mrs_ok;
      bw_go  <= bw_ok;
      if (bw_ok) begin
        bw_bank <= ba;
        bw_col  <= addr[COL_LO +: COL_W];
        bw_mask <= dq_mask;
      end
      if (lock_hit) err_lock <= 1'b1;
      if (nomode_hit) err_nomode <= 1'b1;
      if (mrs_seq || act_seq || bw_seq) err_seq <= 1'b1;
      if (mrs_bad) err_code <= 1'b1;
    end
  end
endmodule

// File: rtl/sgram_cmd_ctrl_chk.sv
module sgram_cmd_ctrl_chk #(
  parameter int NUM_BANKS = 2,
  parameter int BA_W      = 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cke,
  input logic                 cs_n,
  input logic                 ras_n,
  input logic                 cas_n,
  input logic                 we_n,
  input logic                 mode_valid,
  input logic [1:0]           mode_cl,
  input logic [NUM_BANKS-1:0] bank_idle,
  input logic                 busy,
  input logic                 mrs_go,
  input logic                 bw_go,
  input logic [BA_W-1:0]      bw_bank,
  input logic                 err_lock,
  input logic                 err_nomode,
  input logic                 err_seq,
  input logic                 err_code
);
  p_mode_stays_r2: assert property (@(posedge clk) disable iff (rst)
    mode_valid |=> mode_valid);

  p_cl_legal_r3: assert property (@(posedge clk) disable iff (rst)
    mode_valid |-> (mode_cl != 2'd0));

  p_nomode_r4: assert property (@(posedge clk) disable iff (rst)
    (!mode_valid && !busy && cke && !cs_n && !ras_n && cas_n && we_n) |=> err_nomode);

  p_mrs_idle_r6: assert property (@(posedge clk) disable iff (rst)
    mrs_go |-> (&bank_idle));

  p_bw_busy_r8: assert property (@(posedge clk) disable iff (rst)
    bw_go |-> busy);

  p_mrs_busy_r9: assert property (@(posedge clk) disable iff (rst)
    mrs_go |-> busy);

  p_busy_blocks_r10: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!bw_go && !mrs_go));

  p_lock_flag_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && cke && !cs_n && !(ras_n && cas_n && we_n)) |=> err_lock);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (err_lock || err_nomode || err_seq || err_code) |=>
      (err_lock || err_nomode || err_seq || err_code));

  p_cke_freeze_r11: assert property (@(posedge clk) disable iff (rst)
    (!cke && !rst) |=> ($stable(bank_idle) && $stable(busy) && !bw_go && !mrs_go));

  p_bw_open_r12: assert property (@(posedge clk) disable iff (rst)
    bw_go |-> !bank_idle[bw_bank]);
endmodule

bind sgram_cmd_ctrl sgram_cmd_ctrl_chk #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cke       (cke),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .mode_valid(mode_valid),
  .mode_cl   (mode_cl),
  .bank_idle (bank_idle),
  .busy      (busy),
  .mrs_go    (mrs_go),
  .bw_go     (bw_go),
  .bw_bank   (bw_bank),
  .err_lock  (err_lock),
  .err_nomode(err_nomode),
  .err_seq   (err_seq),
  .err_code  (err_code)
);

// File: tb/sim_sgram_cmd_ctrl.sv
module sim_sgram_cmd_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cke = 1'b1;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, dsf = 1'b0;
  logic        ba = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] dq_mask = '0;
  logic        mode_valid, mode_ilv, busy, mrs_go, bw_go, bw_bank;
  logic [1:0]  mode_cl, bank_idle;
  logic [3:0]  mode_burst;
  logic [4:0]  bw_col;
  logic [31:0] bw_mask;
  logic        err_lock, err_nomode, err_seq, err_code;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sgram_cmd_ctrl #(.T_BPL(1), .T_RP(2), .MRS_GAP(2)) u0 (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .dsf(dsf), .ba(ba), .addr(addr), .dq_mask(dq_mask),
    .mode_valid(mode_valid), .mode_cl(mode_cl), .mode_ilv(mode_ilv),
    .mode_burst(mode_burst), .bank_idle(bank_idle), .busy(busy),
    .mrs_go(mrs_go), .bw_go(bw_go), .bw_bank(bw_bank), .bw_col(bw_col),
    .bw_mask(bw_mask), .err_lock(err_lock), .err_nomode(err_nomode),
    .err_seq(err_seq), .err_code(err_code)
  );

  typedef struct packed {
    logic       cke, cs_n, ras_n, cas_n, we_n, dsf, ba;
    logic [9:0] addr;
    logic       e_mv;
    logic [1:0] e_idle;
    logic       e_busy;
    logic [3:0] e_err;
    logic       e_bw, e_mrs;
  } vec_t;

  // e_err = {lock, nomode, seq, code}
  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{1,1,1,1,1,0,0,10'h000, 0,2'b11,0,4'b0000,0,0}, // R1 idle no-op
    '{1,0,0,1,1,0,0,10'h000, 0,2'b11,0,4'b0100,0,0}, // R4 activate before mode
    '{1,0,0,0,0,0,0,10'h002, 0,2'b11,0,4'b0101,0,0}, // R3 latency code 0
    '{1,0,0,0,0,0,0,10'h02B, 1,2'b11,1,4'b0101,0,1}, // R2 R9 good mode load
    '{1,0,0,1,1,0,1,10'h000, 1,2'b11,1,4'b1101,0,0}, // R10 activate in gap
    '{1,1,1,1,1,0,0,10'h000, 1,2'b11,0,4'b1101,0,0}, // R9 gap ends
    '{1,0,0,1,1,0,0,10'h000, 1,2'b10,0,4'b1101,0,0}, // R5 open bank 0
    '{1,0,0,0,0,0,0,10'h02B, 1,2'b10,0,4'b1111,0,0}, // R6 load with bank open
    '{1,0,1,0,1,1,0,10'h2B0, 1,2'b10,1,4'b1111,1,0}, // R7 block write bank 0
    '{1,1,1,1,1,0,0,10'h000, 1,2'b10,1,4'b1111,0,0}, // R8 window 2
    '{1,1,1,1,1,0,0,10'h000, 1,2'b10,1,4'b1111,0,0}, // R8 window 3
    '{1,1,1,1,1,0,0,10'h000, 1,2'b11,0,4'b1111,0,0}, // R8 bank 0 closes
    '{0,0,0,1,1,0,1,10'h000, 1,2'b11,0,4'b1111,0,0}, // R11 cke low ignored
    '{1,0,0,1,1,0,1,10'h000, 1,2'b01,0,4'b1111,0,0}  // R5 open bank 1
  };
  localparam int TREQ [NV] = '{1,4,3,2,10,9,5,6,7,8,8,8,11,5};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic k, input logic c, input logic r, input logic ca,
                       input logic w, input logic d, input logic b, input logic [9:0] a,
                       input logic [31:0] m);
    cke = k; cs_n = c; ras_n = r; cas_n = ca; we_n = w; dsf = d; ba = b;
    addr = a; dq_mask = m;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic nop();
    drive(1, 1, 1, 1, 1, 0, 0, 10'h000, 32'h0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    nop();
    nop();
    rst = 1'b0;
  endtask

  initial begin
    do_reset();
    // R1 reset state
    chk("R1", {mode_valid, bank_idle, busy, err_lock, err_nomode, err_seq, err_code, bw_go, mrs_go},
        {1'b0, 2'b11, 1'b0, 4'b0000, 1'b0, 1'b0});

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].cke, TBL[i].cs_n, TBL[i].ras_n, TBL[i].cas_n, TBL[i].we_n,
            TBL[i].dsf, TBL[i].ba, TBL[i].addr, 32'hA5A5_0F0F);
      chk($sformatf("R%0d vec%0d", TREQ[i], i),
          {mode_valid, bank_idle, busy, err_lock, err_nomode, err_seq, err_code, bw_go, mrs_go},
          {TBL[i].e_mv, TBL[i].e_idle, TBL[i].e_busy, TBL[i].e_err, TBL[i].e_bw, TBL[i].e_mrs});
    end
    // R2 fields from the table load: latency 2, interleaved, 8 beats
    chk("R2 fields", {mode_cl, mode_ilv, mode_burst}, {2'd2, 1'b1, 4'd8});

    // Directed section
    do_reset();
    drive(1, 0, 0, 0, 0, 0, 0, 10'h032, 32'h0);   // latency 3, sequential, 4 beats
    chk("R2 load", {mode_valid, mrs_go, mode_cl, mode_ilv, mode_burst}, {1'b1, 1'b1, 2'd3, 1'b0, 4'd4});
    nop();
    chk("R9 gap 1", busy, 1);
    nop();
    chk("R9 gap end", busy, 0);
    drive(1, 0, 0, 1, 1, 0, 1, 10'h000, 32'h0);   // activate bank 1
    chk("R5 open", bank_idle, 2'b01);
    drive(1, 0, 1, 0, 1, 1, 1, 10'h268, 32'hDEAD_BEEF);
    chk("R7 block", {bw_go, bw_bank, bw_col, bw_mask, busy}, {1'b1, 1'b1, 5'd13, 32'hDEAD_BEEF, 1'b1});
    drive(0, 0, 0, 1, 1, 0, 0, 10'h000, 32'h0);   // cke low, activate ignored
    drive(0, 0, 0, 1, 1, 0, 0, 10'h000, 32'h0);
    chk("R11 hold", {busy, bank_idle, err_lock}, {1'b1, 2'b01, 1'b0});
    drive(1, 0, 1, 1, 1, 0, 0, 10'h000, 32'h0);   // no-op with cs low
    chk("R8 win 2", {busy, bank_idle}, {1'b1, 2'b01});
    drive(1, 0, 1, 1, 1, 0, 0, 10'h000, 32'h0);
    chk("R8 win 3", {busy, bank_idle}, {1'b1, 2'b01});
    drive(1, 0, 1, 1, 1, 0, 0, 10'h000, 32'h0);
    chk("R8 close", {busy, bank_idle}, {1'b0, 2'b11});
    chk("R10 no-op in window", err_lock, 0);
    drive(1, 0, 1, 0, 1, 1, 1, 10'h268, 32'h1);    // block write to idle bank
    chk("R12 idle bank", {bw_go, err_seq, busy}, {1'b0, 1'b1, 1'b0});
    drive(1, 0, 0, 0, 0, 0, 0, 10'h035, 32'h0);    // burst code 5 reserved
    chk("R3 reserved", {err_code, mrs_go, mode_cl, mode_burst}, {1'b1, 1'b0, 2'd3, 4'd4});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule